// File: doc/BRIEF.md
# 2100 Hz Answer-Tone Disable Detector

The block watches a stream of 16-bit signed linear PCM samples, one per strobe at an 8 kHz frame rate. It decides whether a steady answer tone near 2100 Hz is present. When the tone has held long enough, it raises a flag that tells the echo canceller to stop adapting. The samples are grouped into fixed blocks of 160 (20 ms). For each block the design computes two values: the energy in a single frequency bin centred on 2100 Hz, found with a Goertzel recurrence, and the total energy of the block. A block qualifies as tone when its bin energy is above an absolute floor and is also a large enough share of the total energy.

The flag rises after a run of 19 qualifying blocks in a row, which is 380 ms. Any block that does not qualify before the run is complete sends the count back to zero. Once the flag is up, it falls only on level: two blocks in a row whose bin energy is at or below the floor. The floor is set for a sine of about −32 dBm0, which is a peak of about 569 on the 16-bit scale. Dropping the enable forces the flag low and clears all block and run state.

Top module: `tone_det_2100`

## Requirements
- R1: While rst_ni is low and right after it is released, det_o is 0.
- R2: Samples are counted only when smp_vld_i is high. Every 160 counted samples close one block. det_o changes only on the clock edge that follows the strobe that closes a block, or on the edge after en_i goes low.
- R3: Sines at 2075, 2100 and 2125 Hz with a peak of 3000 qualify. Nineteen such blocks in a row assert det_o.
- R4: Sines at 1000, 2025, 2175, 2200 and 3000 Hz with a peak of 3000 never qualify. Nineteen such blocks leave det_o at 0.
- R5: A block qualifies only if its bin energy is above LVL_FLOOR (2072000000, a 2100 Hz sine of peak about 569). A 2100 Hz sine of peak 300 never asserts det_o. A peak of 1000 does.
- R6: det_o rises on the edge after the block that completes the 19th qualifying block in a row. After 18 such blocks it is still 0.
- R7: While det_o is 0, a block that does not qualify resets the run. Another 19 qualifying blocks are then needed.
- R8: While det_o is 1, a block that fails the share test but has bin energy above the floor leaves det_o at 1. An example is a 2100 Hz sine of peak 2000 mixed with a 1000 Hz sine of peak 6000.
- R9: While det_o is 1, a single block at or below the floor does not release it. The second such block in a row clears det_o on the edge after it closes. A block above the floor in between restarts that count.
- R10: en_i low clears det_o on the next edge, ignores samples and clears the run and the partial block. After en_i returns high, 19 new qualifying blocks are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low clears all state |
| smp_vld_i | input | 1 | Sample strobe, one cycle per sample |
| smp_i | input | SMP_W | Signed linear PCM sample |
| det_o | output | 1 | Tone-disable flag |

## Verification
Two cases are the hardest to reach from the ports. The first is the exact block on which the run completes. The second is release hysteresis while the flag is up: a block that is low on level but not yet a release, followed by a block that restarts the release count. The stimulus produces these with phase-continuous synthetic sines. Non-qualifying blocks are placed on purpose: a mixture that fails the share test but stays above the floor, and weak blocks below the floor. The flag is sampled both just before and just after the edge that follows the strobe closing each critical block. A frequency sweep across and beyond the acceptance band is run from a cleared state each time; the enable is pulsed to clear it.

// File: rtl/tdet_pkg.sv
package tdet_pkg;
  localparam int PWR_W = 64;
  typedef logic [PWR_W-1:0] pwr_t;
endpackage

// File: rtl/tdet_framer.sv
module tdet_framer #(
  parameter int N_BLK = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  output logic first_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(N_BLK);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BLK - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= vld_i && (cnt_q == LAST);
      if (vld_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign first_o = (cnt_q == '0);
endmodule

// File: rtl/tdet_energy.sv
module tdet_energy
  import tdet_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int N_BLK = 160
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    vld_i,
  input  logic                    first_i,
  input  logic signed [SMP_W-1:0] smp_i,
  output pwr_t                    tot_o
);
  localparam int SQ_W  = 2 * SMP_W;
  localparam int ACC_W = SQ_W + $clog2(N_BLK);

  logic [SQ_W-1:0]  sq;
  logic [ACC_W-1:0] acc_q;

  assign sq = smp_i * smp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (vld_i)  acc_q <= (first_i ? '0 : acc_q) + ACC_W'(sq);
  end

  assign tot_o = PWR_W'(acc_q);
endmodule

// File: rtl/tdet_goertzel.sv
module tdet_goertzel
  import tdet_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int ST_W   = 32,
  parameter int COEF_W = 16,
  parameter int COEF   = -2571,
  parameter int FRAC   = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    vld_i,
  input  logic                    first_i,
  input  logic signed [SMP_W-1:0] smp_i,
  output pwr_t                    bin_o
);
  localparam logic signed [COEF_W-1:0] COEF_C = COEF_W'(COEF);

  logic signed [ST_W-1:0]        s1_q, s2_q, fb, xe, s_nx;
  logic signed [ST_W+COEF_W-1:0] prod;
  logic signed [PWR_W-1:0]       a1, a2, fe, pw;

  assign prod = s1_q * COEF_C;
  assign fb   = prod[FRAC +: ST_W];   // coef * s1, rescaled
  assign xe   = ST_W'(smp_i);
  assign s_nx = xe + fb - s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (clr_i) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (vld_i) begin
      s1_q <= first_i ? xe : s_nx;
      s2_q <= first_i ? '0 : s1_q;
    end
  end

  // bin power from the final two states: s1^2 + s2^2 - coef*s1*s2
  assign a1 = PWR_W'(s1_q);
  assign a2 = PWR_W'(s2_q);
  assign fe = PWR_W'(fb);
  assign pw = a1 * a1 + a2 * a2 - fe * a2;
  assign bin_o = pw[PWR_W-1] ? '0 : pwr_t'(pw);
endmodule

// File: rtl/tdet_decide.sv
module tdet_decide
  import tdet_pkg::*;
#(
  parameter int   N_BLK      = 160,
  parameter pwr_t LVL_FLOOR  = 64'd2072000000,
  parameter int   FRAC_NUM   = 3,
  parameter int   FRAC_SHIFT = 4,
  parameter int   HOLD_BLKS  = 19,
  parameter int   REL_BLKS   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic done_i,
  input  pwr_t bin_i,
  input  pwr_t tot_i,
  output logic qual_o,
  output logic low_o,
  output logic det_o
);
  localparam int RUN_W = $clog2(HOLD_BLKS + 1);
  localparam int REL_W = $clog2(REL_BLKS + 1);
  localparam pwr_t SHARE_K = PWR_W'(FRAC_NUM * N_BLK);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(HOLD_BLKS - 1);
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(REL_BLKS - 1);

  logic [RUN_W-1:0] run_q;
  logic [REL_W-1:0] rel_q;

  assign low_o  = (bin_i <= LVL_FLOOR);
  assign qual_o = !low_o && ((bin_i << FRAC_SHIFT) >= SHARE_K * tot_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      rel_q <= '0;
      det_o <= 1'b0;
    end else if (clr_i) begin
      run_q <= '0;
      rel_q <= '0;
      det_o <= 1'b0;
    end else if (done_i) begin
      if (!det_o) begin
        rel_q <= '0;
        if (!qual_o)              run_q <= '0;
        else if (run_q == RUN_LAST) begin
          run_q <= '0;
          det_o <= 1'b1;
        end else                  run_q <= run_q + 1'b1;
      end else begin
        if (!low_o)               rel_q <= '0;
        else if (rel_q == REL_LAST) begin
          rel_q <= '0;
          det_o <= 1'b0;
        end else                  rel_q <= rel_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tone_det_2100.sv
module tone_det_2100
  import tdet_pkg::*;
#(
  parameter int   SMP_W      = 16,
  parameter int   N_BLK      = 160,
  parameter int   ST_W       = 32,
  parameter int   COEF_W     = 16,
  parameter int   COEF       = -2571,
  parameter int   COEF_FRAC  = 14,
  parameter pwr_t LVL_FLOOR  = 64'd2072000000,
  parameter int   FRAC_NUM   = 3,
  parameter int   FRAC_SHIFT = 4,
  parameter int   HOLD_BLKS  = 19,
  parameter int   REL_BLKS   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             det_o
);
  logic clr, first, blk_done, blk_qual, blk_low;
  pwr_t bin_pwr, tot_pwr;
  logic signed [SMP_W-1:0] smp_s;

  assign clr   = !en_i;
  assign smp_s = smp_i;

  tdet_framer #(.N_BLK(N_BLK)) u_frm (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .vld_i(smp_vld_i),
    .first_o(first), .done_o(blk_done)
  );

  tdet_goertzel #(
    .SMP_W(SMP_W), .ST_W(ST_W), .COEF_W(COEF_W), .COEF(COEF), .FRAC(COEF_FRAC)
  ) u_grz (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .vld_i(smp_vld_i),
    .first_i(first), .smp_i(smp_s), .bin_o(bin_pwr)
  );

  tdet_energy #(.SMP_W(SMP_W), .N_BLK(N_BLK)) u_nrg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .vld_i(smp_vld_i),
    .first_i(first), .smp_i(smp_s), .tot_o(tot_pwr)
  );

  tdet_decide #(
    .N_BLK(N_BLK), .LVL_FLOOR(LVL_FLOOR), .FRAC_NUM(FRAC_NUM),
    .FRAC_SHIFT(FRAC_SHIFT), .HOLD_BLKS(HOLD_BLKS), .REL_BLKS(REL_BLKS)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .done_i(blk_done),
    .bin_i(bin_pwr), .tot_i(tot_pwr), .qual_o(blk_qual), .low_o(blk_low),
    .det_o(det_o)
  );
endmodule

// File: rtl/tdet_chk.sv
module tdet_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic det_o,
  input logic blk_done,
  input logic blk_qual,
  input logic blk_low
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done |=> !blk_done);                                              // R2
  AST_RISE_AT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> $past(blk_done) && $past(en_i));                     // R2
  AST_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(det_o) |-> !$past(en_i) || $past(blk_done));                    // R2
  AST_RISE_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> $past(blk_qual));                                    // R6
  AST_FALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(det_o) && $past(en_i) |-> $past(blk_low));                      // R9
  AST_HOLD_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done && det_o && !blk_low && en_i |=> det_o);                     // R8
  AST_EN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !det_o);                                                    // R10
endmodule

bind tone_det_2100 tdet_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .det_o(det_o),
  .blk_done(blk_done), .blk_qual(blk_qual), .blk_low(blk_low)
);

// File: tb/sim_tone_det_2100.sv
`timescale 1ns/1ps
module sim_tone_det_2100;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic vld = 1'b0;
  logic [15:0] smp = '0;
  logic det;
  int n_chk = 0, n_fail = 0, n_smp = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tone_det_2100 u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .smp_vld_i(vld), .smp_i(smp), .det_o(det)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: det_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  // one 160-sample block of two summed sines, phase continuous
  task automatic send_blk(input real f1, input int a1, input real f2, input int a2);
    for (int i = 0; i < 160; i++) begin
      real t;
      @(negedge clk);
      t = 6.283185307179586 * real'(n_smp) / 8000.0;
      smp = 16'($rtoi(real'(a1) * $sin(f1 * t) + real'(a2) * $sin(f2 * t)));
      vld = 1'b1;
      n_smp++;
      @(negedge clk);
      vld = 1'b0;
    end
  endtask

  task automatic blks(input int n, input real f, input int a);
    for (int k = 0; k < n; k++) send_blk(f, a, 0.0, 0);
  endtask

  // check flag just before and just after the edge following the closing strobe
  task automatic blk_chk(input real f1, input int a1, input real f2, input int a2,
                         input logic pre, input logic post, input string tag);
    send_blk(f1, a1, f2, a2);
    check(det, pre, tag);
    @(negedge clk);
    check(det, post, tag);
  endtask

  task automatic pulse_en();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    real acc_f[3];
    real rej_f[5];
    acc_f = '{2075.0, 2100.0, 2125.0};
    rej_f = '{1000.0, 2025.0, 2175.0, 2200.0, 3000.0};
    repeat (3) @(negedge clk);
    check(det, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(det, 1'b0, "R1 after release");

    // persistence: exact block of assertion
    blks(18, 2100.0, 4000);
    check(det, 1'b0, "R6 after 18 blocks");
    blk_chk(2100.0, 4000, 0.0, 0, 1'b0, 1'b1, "R2 R6 rise after block 19");

    // share test fails, level above floor: hold
    blk_chk(2100.0, 2000, 1000.0, 6000, 1'b1, 1'b1, "R8 mix block 1");
    blk_chk(2100.0, 2000, 1000.0, 6000, 1'b1, 1'b1, "R8 mix block 2");

    // release hysteresis
    blk_chk(2100.0, 200, 0.0, 0, 1'b1, 1'b1, "R9 single low");
    blk_chk(2100.0, 4000, 0.0, 0, 1'b1, 1'b1, "R9 strong resets count");
    blk_chk(2100.0, 200, 0.0, 0, 1'b1, 1'b1, "R9 first low");
    blk_chk(2100.0, 200, 0.0, 0, 1'b1, 1'b0, "R9 second low releases");

    // run restart
    blks(10, 2100.0, 4000);
    blk_chk(1000.0, 4000, 0.0, 0, 1'b0, 1'b0, "R7 break block");
    blks(18, 2100.0, 4000);
    check(det, 1'b0, "R7 18 after break");
    blk_chk(2100.0, 4000, 0.0, 0, 1'b0, 1'b1, "R7 19 after break");

    // enable
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check(det, 1'b0, "R10 cleared next edge");
    blks(5, 2100.0, 4000);
    check(det, 1'b0, "R10 ignored while low");
    en = 1'b1;
    blks(18, 2100.0, 4000);
    check(det, 1'b0, "R10 run restarted");
    blk_chk(2100.0, 4000, 0.0, 0, 1'b0, 1'b1, "R10 full run after enable");

    // frequency sweep
    foreach (acc_f[i]) begin
      pulse_en();
      blks(19, acc_f[i], 3000);
      @(negedge clk);
      check(det, 1'b1, $sformatf("R3 accept %0d Hz", $rtoi(acc_f[i])));
    end
    foreach (rej_f[i]) begin
      pulse_en();
      blks(19, rej_f[i], 3000);
      @(negedge clk);
      check(det, 1'b0, $sformatf("R4 reject %0d Hz", $rtoi(rej_f[i])));
    end

    // level floor
    pulse_en();
    blks(19, 2100.0, 1000);
    @(negedge clk);
    check(det, 1'b1, "R5 peak 1000 above floor");
    pulse_en();
    blks(19, 2100.0, 300);
    @(negedge clk);
    check(det, 1'b0, "R5 peak 300 below floor");

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule